// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block supervises an SRAM whose contents are backed by a nonvolatile array. Two digital flags report the supply condition: one says the supply has dropped below the switch threshold, the other says it has dropped below the lower reset threshold. From these, from store requests that arrive by software pulse or by a hardware request pin, and from its own record of whether the SRAM has been written since the last transfer, the block decides when to copy the SRAM into the array (store) and when to copy the array back (recall). It gates SRAM writes and drives an active-low busy output.

A recall request is latched at reset and whenever the supply sinks below the reset level. The recall itself waits until the supply is back above the switch threshold. In auto-store mode a supply drop below the switch threshold starts a store, if anything was written. In inhibit mode supply drops never store. The mode strap is captured only while reset is held. Store and recall commands go to the array over a valid/ready request channel: the block raises `nv_req_valid` with the operation on `nv_req_recall`, holds both steady until `nv_req_ready` is seen high at a clock edge, and then waits for a one-cycle `nv_done` pulse. The array may hold ready low for as long as it likes. Each operation also keeps a minimum length in clock cycles, set by a parameter. It ends at the later of that window and `nv_done`.

Top module: `nv_powerfail_seq`

## Requirements
- R1: While reset is held, `busy_n` is 0. A recall is pending out of reset, and it starts only once `sup_below_switch` is 0.
- R2: `sup_below_reset` high latches a recall request. The recall starts on the first clock edge that sees `sup_below_switch` low. `busy_n` stays 0 for RECALL_CYC cycles from that edge, or longer if `nv_done` is later.
- R3: While `sup_below_switch` is 1, `sram_wr_ok` is 0 and software or hardware store requests are ignored.
- R4: A store request from any source, made when no write has been accepted since the last completed store or recall, issues no command and leaves `busy_n` at 1.
- R5: In auto-store mode (strap 0), `sup_below_switch` rising while writes are pending starts a store. `busy_n` falls within one cycle and stays 0 until `sup_below_switch` returns to 0. With nothing written, `busy_n` still falls but no command is issued.
- R6: In inhibit mode (strap 1), a supply drop never starts a store, and `busy_n` stays 1. Software and hardware requests still store.
- R7: A store keeps `busy_n` at 0 for STORE_CYC cycles, or until `nv_done` if that is later. `sram_wr_ok` is 0 throughout.
- R8: `mode_inhibit_strap` is sampled only while `rst_n` is 0. Later changes have no effect.
- R9: An accepted write (`sram_wr_req` with `sram_wr_ok` high) marks the SRAM dirty. A completed store or recall clears the mark.
- R10: If `sup_below_reset` rises during a power-fail store, the store is abandoned and a recall runs at the next return above the switch threshold.
- R11: `nv_req_valid` with `nv_req_recall` (1 = recall, 0 = store) holds steady until accepted. Each operation sends exactly one command.
- R12: A rising edge of `hw_store_req` requests a store. While the pin is high, `sram_wr_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| mode_inhibit_strap | input | 1 | 1 = supply drops never store; sampled in reset |
| sup_below_switch | input | 1 | Supply under switch threshold |
| sup_below_reset | input | 1 | Supply under reset threshold |
| hw_store_req | input | 1 | Hardware store request pin, rising edge |
| sw_store_req | input | 1 | One-cycle pulse from software sequence detector |
| sram_wr_req | input | 1 | SRAM write attempt |
| sram_wr_ok | output | 1 | Write permitted this cycle |
| nv_req_valid | output | 1 | Array command valid |
| nv_req_ready | input | 1 | Array accepts command |
| nv_req_recall | output | 1 | Command kind: 1 recall, 0 store |
| nv_done | input | 1 | Array operation finished (pulse) |
| busy_n | output | 1 | Active-low busy |

## Verification
The hardest case to reach is a store abandoned partway through. The supply must first cross the switch threshold with writes pending. The reset-level flag must then rise while the array is still inside its store window, and the supply must later recover. The stimulus writes once, raises the switch flag, waits ten cycles, pulses the reset flag, and only then lowers both. The scoreboard must then see exactly one store followed by one recall. A store request made afterwards must produce no command, which shows that the recall cleared the dirty mark. Back-pressure is covered by holding ready low for several cycles on one store while the busy length is measured.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DOWN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/nvps_status.sv
module nvps_status (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_strap,
  input  logic hw_pin,
  input  logic sw_req,
  input  logic wr_accept,
  input  logic vlow_reset,
  input  logic op_done,
  input  logic op_recall,
  output logic inhibit,
  output logic dirty,
  output logic recall_pend,
  output logic ext_req
);
  logic hw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit     <= mode_strap;
      dirty       <= 1'b0;
      recall_pend <= 1'b1;
      hw_q        <= hw_pin;
    end else begin
      hw_q <= hw_pin;
      if (vlow_reset)                recall_pend <= 1'b1;
      else if (op_done && op_recall) recall_pend <= 1'b0;
      if (op_done)        dirty <= 1'b0;
      else if (wr_accept) dirty <= 1'b1;
    end
  end

  assign ext_req = sw_req | (hw_pin & ~hw_q);

  // R8: mode is frozen once out of reset
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(inhibit));

  // R2: the recall latch only drops when a recall completes
  p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recall_pend) |-> $past(op_done && op_recall));
endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic op_recall,
  output logic expired
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STORE_LIM  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RECALL_LIM = CW'(RECALL_CYC - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit   = op_recall ? RECALL_LIM : STORE_LIM;
  assign expired = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R7: window counter never passes its limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/nvps_fsm.sv
module nvps_fsm import nvps_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit,
  input  logic       dirty,
  input  logic       recall_pend,
  input  logic       ext_req,
  input  logic       vlow_switch,
  input  logic       vlow_reset,
  input  logic       req_ready,
  input  logic       nv_done,
  input  logic       expired,
  output seq_state_e state_q,
  output logic       op_q,
  output logic       op_done,
  output logic       run
);
  seq_state_e state_d;
  logic       op_d;
  logic       done_seen;
  logic       abort;

  assign run   = (state_q == ST_CMD) || (state_q == ST_RUN);
  assign abort = op_q ? vlow_switch : vlow_reset;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    op_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (recall_pend && !vlow_switch) begin
          op_d = 1'b1; state_d = ST_CMD;
        end else if (vlow_switch) begin
          if (!inhibit) begin
            if (dirty) begin op_d = 1'b0; state_d = ST_CMD; end
            else state_d = ST_DOWN;
          end
        end else if (ext_req && dirty) begin
          op_d = 1'b0; state_d = ST_CMD;
        end
      end
      ST_CMD, ST_RUN: begin
        if (abort) state_d = ST_DOWN;
        else if (state_q == ST_CMD) begin
          if (req_ready) state_d = ST_RUN;
        end else if (expired && (done_seen || nv_done)) begin
          op_done = 1'b1;
          state_d = vlow_switch ? ST_DOWN : ST_IDLE;
        end
      end
      ST_DOWN: begin
        if (!vlow_switch) begin
          if (recall_pend) begin op_d = 1'b1; state_d = ST_CMD; end
          else state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_DOWN;
      op_q      <= 1'b1;
      done_seen <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      done_seen <= (state_d == ST_RUN) &&
                   (done_seen || ((state_q == ST_RUN) && nv_done));
    end
  end

  // R11: command held steady until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && !req_ready && !abort) |=> (state_q == ST_CMD) && $stable(op_q));

  // R4: a store command only leaves when the SRAM is dirty
  p_store_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && state_d == ST_CMD && !op_d) |-> dirty);

  // R2: no recall is issued while supply is below the switch level
  p_recall_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && op_q) |-> !vlow_switch);

  // R5: auto mode leaves idle at once on a supply drop
  p_pf_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && vlow_switch && !inhibit) |=> (state_q != ST_IDLE));

  // R6: inhibit mode stays idle through a supply drop
  p_inh_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && vlow_switch && inhibit && !recall_pend) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/nv_powerfail_seq.sv
module nv_powerfail_seq import nvps_pkg::*; #(
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_inhibit_strap,
  input  logic sup_below_switch,
  input  logic sup_below_reset,
  input  logic hw_store_req,
  input  logic sw_store_req,
  input  logic sram_wr_req,
  output logic sram_wr_ok,
  output logic nv_req_valid,
  input  logic nv_req_ready,
  output logic nv_req_recall,
  input  logic nv_done,
  output logic busy_n
);
  seq_state_e state;
  logic op_recall, op_done, run, expired;
  logic inhibit, dirty, recall_pend, ext_req;

  nvps_status u_status (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_inhibit_strap),
    .hw_pin(hw_store_req), .sw_req(sw_store_req), .wr_accept(sram_wr_ok),
    .vlow_reset(sup_below_reset), .op_done(op_done), .op_recall(op_recall),
    .inhibit(inhibit), .dirty(dirty), .recall_pend(recall_pend), .ext_req(ext_req)
  );

  nvps_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .op_recall(op_recall), .expired(expired)
  );

  nvps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .dirty(dirty),
    .recall_pend(recall_pend), .ext_req(ext_req), .vlow_switch(sup_below_switch),
    .vlow_reset(sup_below_reset), .req_ready(nv_req_ready), .nv_done(nv_done),
    .expired(expired), .state_q(state), .op_q(op_recall), .op_done(op_done), .run(run)
  );

  assign nv_req_valid  = (state == ST_CMD);
  assign nv_req_recall = op_recall;
  assign busy_n        = (state == ST_IDLE);
  assign sram_wr_ok    = sram_wr_req && (state == ST_IDLE) &&
                         !sup_below_switch && !hw_store_req;
endmodule

// File: tb/nv_powerfail_seq_tb_top.sv
module nv_powerfail_seq_tb_top;
  localparam int SC = 40;
  localparam int RC = 24;

  logic clk = 1'b0;
  logic rst_n, strap, vsw, vrst, hw, sw, wr_req, wr_ok;
  logic nv_valid, nv_ready, nv_recall, nv_done, busy_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit exp_q[$];
  int stall_left = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nv_powerfail_seq #(.STORE_CYC(SC), .RECALL_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_inhibit_strap(strap),
    .sup_below_switch(vsw), .sup_below_reset(vrst), .hw_store_req(hw),
    .sw_store_req(sw), .sram_wr_req(wr_req), .sram_wr_ok(wr_ok),
    .nv_req_valid(nv_valid), .nv_req_ready(nv_ready), .nv_req_recall(nv_recall),
    .nv_done(nv_done), .busy_n(busy_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Array model and scoreboard monitor
  initial begin
    bit hs_pending = 1'b0;
    bit op_saved   = 1'b0;
    int done_cnt   = 0;
    nv_ready = 1'b0;
    nv_done  = 1'b0;
    forever begin
      @(negedge clk);
      if (hs_pending) begin
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected command", int'(op_saved), -1);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(op_saved == e, "R11 command kind", int'(op_saved), int'(e));
        end
        done_cnt = 5;
      end
      nv_done = (done_cnt == 1);
      if (done_cnt > 0) done_cnt--;
      if (nv_valid) begin
        if (stall_left > 0) begin stall_left--; nv_ready = 1'b0; end
        else nv_ready = 1'b1;
      end else nv_ready = 1'b0;
      hs_pending = nv_valid && nv_ready;
      op_saved   = nv_recall;
    end
  end

  task automatic busy_len(output int n);
    n = 0;
    while (busy_n == 1'b0 && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic do_write();
    wr_req = 1'b1;
    #0 check(wr_ok == 1'b1, "R9 write accepted in idle", int'(wr_ok), 1);
    @(negedge clk); wr_req = 1'b0;
  endtask

  task automatic sw_pulse();
    sw = 1'b1; @(negedge clk); sw = 1'b0;
  endtask

  task automatic power_on(input bit mode);
    int n;
    rst_n = 1'b0; strap = mode; vsw = 1'b1; vrst = 1'b1;
    hw = 1'b0; sw = 1'b0; wr_req = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_n == 1'b0, "R1 busy in reset", int'(busy_n), 0);
    check(wr_ok == 1'b0, "R1 no write in reset", int'(wr_ok), 0);
    rst_n = 1'b1; wr_req = 1'b0;
    @(negedge clk); vrst = 1'b0;
    repeat (6) @(negedge clk);
    check(busy_n == 1'b0, "R1 recall waits for switch level", int'(busy_n), 0);
    exp_q.push_back(1'b1);
    vsw = 1'b0;
    busy_len(n);
    check(n == RC + 1, "R2 power-up recall length", n, RC + 1);
  endtask

  initial begin
    int n;
    power_on(1'b0);

    // R4: clean store request
    sw_pulse();
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R4 clean sw store does nothing", int'(busy_n), 1);

    // R7 R11: store with back-pressure, writes blocked
    do_write();
    stall_left = 3;
    exp_q.push_back(1'b0);
    sw_pulse();
    wr_req = 1'b1;
    #0 check(wr_ok == 1'b0, "R7 write blocked during store", int'(wr_ok), 0);
    busy_len(n);
    wr_req = 1'b0;
    check(n == SC, "R7 store length with stall", n, SC);

    // R9: dirty cleared by store
    sw_pulse();
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R9 store cleared dirty", int'(busy_n), 1);

    // R12: pin high blocks writes; rising edge stores
    hw = 1'b1; wr_req = 1'b1;
    #0 check(wr_ok == 1'b0, "R12 write blocked while pin high", int'(wr_ok), 0);
    @(negedge clk); wr_req = 1'b0;
    check(busy_n == 1'b1, "R4 clean hw store does nothing", int'(busy_n), 1);
    hw = 1'b0; @(negedge clk);
    do_write();
    exp_q.push_back(1'b0);
    hw = 1'b1; @(negedge clk);
    busy_len(n);
    check(n == SC, "R12 hw store length", n, SC);
    hw = 1'b0; @(negedge clk);

    // R5 R3: power-fail store
    do_write();
    exp_q.push_back(1'b0);
    vsw = 1'b1; @(negedge clk);
    check(busy_n == 1'b0, "R5 busy within one cycle", int'(busy_n), 0);
    repeat (SC + 10) @(negedge clk);
    check(busy_n == 1'b0, "R5 busy held while supply low", int'(busy_n), 0);
    wr_req = 1'b1;
    #0 check(wr_ok == 1'b0, "R3 write blocked below switch", int'(wr_ok), 0);
    wr_req = 1'b0;
    vsw = 1'b0; @(negedge clk);
    check(busy_n == 1'b1, "R5 busy released, no recall", int'(busy_n), 1);
    sw_pulse(); repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R9 power-fail store cleared dirty", int'(busy_n), 1);

    // R5: clean power drop
    vsw = 1'b1; @(negedge clk);
    check(busy_n == 1'b0, "R5 clean drop still busy", int'(busy_n), 0);
    repeat (5) @(negedge clk);
    vsw = 1'b0; @(negedge clk);
    check(busy_n == 1'b1, "R5 clean drop no command", int'(busy_n), 1);

    // R10: abandoned store, recall later
    do_write();
    exp_q.push_back(1'b0);
    vsw = 1'b1;
    repeat (10) @(negedge clk);
    vrst = 1'b1; repeat (3) @(negedge clk);
    vrst = 1'b0; repeat (SC + 10) @(negedge clk);
    check(busy_n == 1'b0, "R10 still down after abandon", int'(busy_n), 0);
    exp_q.push_back(1'b1);
    vsw = 1'b0;
    busy_len(n);
    check(n == RC + 1, "R10 recall after abandoned store", n, RC + 1);
    sw_pulse(); repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R9 recall cleared dirty", int'(busy_n), 1);

    // R6 R8: inhibit mode
    power_on(1'b1);
    strap = 1'b0;
    do_write();
    vsw = 1'b1; @(negedge clk);
    check(busy_n == 1'b1, "R6 no busy on drop in inhibit", int'(busy_n), 1);
    repeat (5) @(negedge clk);
    check(busy_n == 1'b1, "R8 strap change ignored", int'(busy_n), 1);
    wr_req = 1'b1;
    #0 check(wr_ok == 1'b0, "R3 write blocked below switch (inhibit)", int'(wr_ok), 0);
    wr_req = 1'b0;
    sw_pulse(); @(negedge clk);
    check(busy_n == 1'b1, "R3 sw store ignored below switch", int'(busy_n), 1);
    vsw = 1'b0; @(negedge clk);
    exp_q.push_back(1'b0);
    sw_pulse();
    busy_len(n);
    check(n == SC, "R6 sw store in inhibit mode", n, SC);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected commands seen", exp_q.size(), 0);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      report();
    end
  end
endmodule